// File: doc/BRIEF.md
# Interleaved DRAM Phase Arbiter

This block owns a single shared DRAM and hands out its memory slots in a fixed rhythm. Time is divided into slot pairs of four processor clocks. A slot pair holds one two-clock display slot and then one two-clock processor slot. The display slot always does work. It runs a video fetch when the display side has one pending. Otherwise it runs a row-only refresh at a row counter that steps once per refresh. The display slot is never lent to the processor side, even when the display side has nothing to fetch.

Processor-side masters use a level strobe held until acknowledge. Each access carries a flag that says whether it targets DRAM. DRAM accesses are granted only at the single decision point before a processor slot. As a result, every DRAM acknowledge rises at the same position in the slot pair. An access that starts half a pair out of step waits two extra clocks. Read data is latched when the slot closes and stays on the bus while the master finishes its longer cycle. A write is committed inside the slot, and the DRAM moves on even if the master still holds its strobe. Accesses that do not target DRAM are acknowledged at once.

Top module: `dram_phase_arb`

## Requirements
- R1: Out of reset the phase output is 0, acknowledge outputs are low and the column strobe is low. The phase then steps 0,1,2,3 and wraps to 0, one step per clock. Phases 0–1 are the display slot and phases 2–3 are the processor slot.
- R2: If the video request is high in the phase-3 cycle, the next display slot is a video fetch. Row strobe is high in phases 0 and 1. Column strobe and column select are high in phase 1 only. The address pins carry the upper half of the video address in phase 0 and the lower half in phase 1. A video fetch takes precedence over refresh.
- R3: A display slot with no video fetch is a refresh. Row strobe is high in both clocks, column strobe stays low, and the address pins carry a refresh row. The refresh row increases by one after each refresh.
- R4: Write enable is never high in phases 0 or 1, and a processor access never drives the DRAM during a display slot.
- R5: A DRAM access whose strobe is first high in a phase-1 cycle gets its slot in phases 2–3. Acknowledge goes high three clocks later, in phase 0.
- R6: Every DRAM acknowledge rises in a phase-0 cycle. A strobe first high in phase 3 sees acknowledge five clocks later, which is two wait clocks more than the aligned case. A strobe first high in phase 0 sees acknowledge four clocks later.
- R7: For a read, the data-in value present while the column strobe is high in phase 3 is latched. That value is presented on the read-data output and held unchanged while acknowledge stays high.
- R8: A write drives write enable and the write data in both processor-slot clocks (phases 2 and 3) and in no other cycle. Exactly two write-enable cycles occur per write access.
- R9: Acknowledge stays high while the strobe is held and falls one clock after the strobe drops. A held strobe never receives a second slot.
- R10: An access with the DRAM flag low is acknowledged one clock after the strobe is first high, in any phase, and causes no DRAM processor slot.
- R11: After a video fetch, the video acknowledge pulses high for the phase-2 cycle only. The video data output then holds the data-in value latched in phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_as_i | input | 1 | Processor-side access strobe, held until acknowledge |
| cpu_dram_i | input | 1 | Access targets DRAM |
| cpu_we_i | input | 1 | Access is a write |
| cpu_addr_i | input | ADDR_W | Processor-side address |
| cpu_wdata_i | input | DATA_W | Processor-side write data |
| cpu_ack_o | output | 1 | Acknowledge to processor side |
| cpu_rdata_o | output | DATA_W | Latched read data |
| vid_req_i | input | 1 | Video fetch wanted in the next display slot |
| vid_addr_i | input | ADDR_W | Video fetch address |
| vid_ack_o | output | 1 | Video data valid pulse |
| vid_data_o | output | DATA_W | Latched video data |
| dram_ras_o | output | 1 | Row strobe |
| dram_cas_o | output | 1 | Column strobe |
| dram_we_o | output | 1 | Write enable |
| dram_col_sel_o | output | 1 | Address mux select, high for column |
| dram_addr_o | output | ADDR_W/2 | Multiplexed DRAM address |
| dram_wdata_o | output | DATA_W | Data to DRAM |
| dram_rdata_i | input | DATA_W | Data from DRAM |
| phase_o | output | 2 | Current slot phase |

## Verification
Several properties are checked on every clock. The phase must wrap from 3 to 0. Write enable must never appear in a display slot. A refresh slot must never raise the column strobe. A DRAM acknowledge must rise only in phase 0, and acknowledge must fall once the strobe is gone.

Other behaviours only the scenarios can show. These are the exact wait-state counts for each starting phase, the latched read and video values and how long they are held, and the one-step refresh row sequence. They also include video taking precedence over refresh, and the fixed two-cycle write window while the strobe is still held. These are covered by a cycle-level reference model and by targeted latency and data checks.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;
  typedef enum logic [1:0] {
    PH_DISP_ROW = 2'd0,
    PH_DISP_COL = 2'd1,
    PH_CPU_ROW  = 2'd2,
    PH_CPU_COL  = 2'd3
  } phase_e;
endpackage

// File: rtl/arb_phase_ctr.sv
module arb_phase_ctr
  import dram_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  phase_e cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= PH_DISP_ROW;
    else         cnt_q <= phase_e'(cnt_q + 2'd1);
  end

  assign phase_o = cnt_q;

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == PH_CPU_COL) |=> (cnt_q == PH_DISP_ROW));
endmodule

// File: rtl/arb_disp_sched.sv
module arb_disp_sched
  import dram_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int ROW_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              vid_req_i,
  input  logic [ADDR_W-1:0] vid_addr_i,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              vid_sel_o,
  output logic [ADDR_W-1:0] vid_addr_q_o,
  output logic [ROW_W-1:0]  ref_row_o,
  output logic              vid_ack_o,
  output logic [DATA_W-1:0] vid_data_o
);
  logic              vid_sel_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [ROW_W-1:0]  ref_q;
  logic              vack_q;
  logic [DATA_W-1:0] vdata_q;

  // slot owner fixed one clock before the display slot opens
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_sel_q <= 1'b0;
      vaddr_q   <= '0;
    end else if (phase_i == PH_CPU_COL) begin
      vid_sel_q <= vid_req_i;
      vaddr_q   <= vid_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      vack_q  <= 1'b0;
      vdata_q <= '0;
    end else begin
      vack_q <= (phase_i == PH_DISP_COL) && vid_sel_q;
      if (phase_i == PH_DISP_COL) begin
        if (vid_sel_q) vdata_q <= dram_rdata_i;
        else           ref_q   <= ref_q + 1'b1;
      end
    end
  end

  assign vid_sel_o    = vid_sel_q;
  assign vid_addr_q_o = vaddr_q;
  assign ref_row_o    = ref_q;
  assign vid_ack_o    = vack_q;
  assign vid_data_o   = vdata_q;

  p_vack_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vack_q |-> (phase_i == PH_CPU_ROW));
endmodule

// File: rtl/arb_cpu_port.sv
module arb_cpu_port
  import dram_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              as_i,
  input  logic              dram_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic              slot_o,
  output logic              we_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              slot_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              grant, slot_end;

  // single decision point: the clock before the processor slot
  assign grant    = (phase_i == PH_DISP_COL) && as_i && dram_i && !done_q && !slot_q;
  assign slot_end = (phase_i == PH_CPU_COL) && slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (grant) begin
      slot_q  <= 1'b1;
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end else if (slot_end) begin
      slot_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (slot_end && !we_q) rdata_q <= dram_rdata_i;
      if (!as_i)                      done_q <= 1'b0;
      else if (slot_end)              done_q <= 1'b1;
      else if (!dram_i && !done_q)    done_q <= 1'b1;
    end
  end

  assign slot_o    = slot_q;
  assign we_q_o    = we_q;
  assign addr_q_o  = addr_q;
  assign wdata_q_o = wdata_q;
  assign ack_o     = done_q;
  assign rdata_o   = rdata_q;

  p_ack_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_q) && dram_i) |-> (phase_i == PH_DISP_ROW));
  p_ack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !as_i) |=> !done_q);
  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && $past(done_q)) |-> $stable(rdata_q));
endmodule

// File: rtl/dram_phase_arb.sv
module dram_phase_arb
  import dram_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int ROW_W = ADDR_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_as_i,
  input  logic              cpu_dram_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              vid_req_i,
  input  logic [ADDR_W-1:0] vid_addr_i,
  output logic              vid_ack_o,
  output logic [DATA_W-1:0] vid_data_o,
  output logic              dram_ras_o,
  output logic              dram_cas_o,
  output logic              dram_we_o,
  output logic              dram_col_sel_o,
  output logic [ROW_W-1:0]  dram_addr_o,
  output logic [DATA_W-1:0] dram_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i,
  output logic [1:0]        phase_o
);
  phase_e            phase;
  logic              vid_sel, slot, we_q;
  logic [ADDR_W-1:0] vaddr_q, caddr_q;
  logic [ROW_W-1:0]  ref_row;

  arb_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  arb_disp_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_disp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase),
    .vid_req_i    (vid_req_i),
    .vid_addr_i   (vid_addr_i),
    .dram_rdata_i (dram_rdata_i),
    .vid_sel_o    (vid_sel),
    .vid_addr_q_o (vaddr_q),
    .ref_row_o    (ref_row),
    .vid_ack_o    (vid_ack_o),
    .vid_data_o   (vid_data_o)
  );

  arb_cpu_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cpu (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_i      (phase),
    .as_i         (cpu_as_i),
    .dram_i       (cpu_dram_i),
    .we_i         (cpu_we_i),
    .addr_i       (cpu_addr_i),
    .wdata_i      (cpu_wdata_i),
    .dram_rdata_i (dram_rdata_i),
    .slot_o       (slot),
    .we_q_o       (we_q),
    .addr_q_o     (caddr_q),
    .wdata_q_o    (dram_wdata_o),
    .ack_o        (cpu_ack_o),
    .rdata_o      (cpu_rdata_o)
  );

  logic col_phase;
  assign col_phase = phase[0];

  always_comb begin
    dram_ras_o     = 1'b0;
    dram_cas_o     = 1'b0;
    dram_we_o      = 1'b0;
    dram_col_sel_o = 1'b0;
    dram_addr_o    = '0;
    if (!phase[1]) begin
      dram_ras_o = 1'b1;
      if (vid_sel) begin
        dram_cas_o     = col_phase;
        dram_col_sel_o = col_phase;
        dram_addr_o    = col_phase ? vaddr_q[ROW_W-1:0] : vaddr_q[ADDR_W-1 -: ROW_W];
      end else begin
        dram_addr_o    = ref_row;
      end
    end else if (slot) begin
      dram_ras_o     = 1'b1;
      dram_cas_o     = col_phase;
      dram_col_sel_o = col_phase;
      dram_we_o      = we_q;
      dram_addr_o    = col_phase ? caddr_q[ROW_W-1:0] : caddr_q[ADDR_W-1 -: ROW_W];
    end
  end

  assign phase_o = phase;

  p_no_cpu_in_disp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[1] |-> !dram_we_o);
  p_refresh_no_cas_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_o[1] && !vid_sel) |-> !dram_cas_o);
endmodule

// File: tb/dram_phase_arb_tb.sv
module dram_phase_arb_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int RW = AW / 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_as = 0, cpu_dram = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic          vid_req = 0;
  logic [AW-1:0] vid_addr = '0;
  logic          vid_ack;
  logic [DW-1:0] vid_data;
  logic          ras, cas, we, col_sel;
  logic [RW-1:0] daddr;
  logic [DW-1:0] dwdata, drdata;
  logic [1:0]    phase;

  int n_chk = 0, n_err = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  // behavioural DRAM: data is a function of the column address
  assign drdata = cas ? {daddr, ~daddr} : '0;

  dram_phase_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_as_i(cpu_as), .cpu_dram_i(cpu_dram), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .vid_req_i(vid_req), .vid_addr_i(vid_addr),
    .vid_ack_o(vid_ack), .vid_data_o(vid_data),
    .dram_ras_o(ras), .dram_cas_o(cas), .dram_we_o(we),
    .dram_col_sel_o(col_sel), .dram_addr_o(daddr),
    .dram_wdata_o(dwdata), .dram_rdata_i(drdata), .phase_o(phase)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model state
  int            m_ph;
  bit            m_vid, m_slot, m_we, m_done, m_vack;
  logic [AW-1:0] m_vaddr, m_caddr;
  logic [RW-1:0] m_ref;
  logic [DW-1:0] m_wd, m_rd, m_vd;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_vid = 0; m_slot = 0; m_we = 0; m_done = 0; m_vack = 0;
      m_vaddr = '0; m_caddr = '0; m_ref = '0; m_wd = '0; m_rd = '0; m_vd = '0;
    end else begin
      automatic int ph = m_ph;
      automatic bit slot_old = m_slot;
      automatic bit done_old = m_done;
      m_vack = (ph == 1) && m_vid;
      if (ph == 1) begin
        if (m_vid) m_vd = {m_vaddr[RW-1:0], ~m_vaddr[RW-1:0]};
        else       m_ref = m_ref + 1'b1;
        if (cpu_as && cpu_dram && !done_old && !slot_old) begin
          m_slot = 1; m_we = cpu_we; m_caddr = cpu_addr; m_wd = cpu_wdata;
        end
      end
      if (ph == 3) begin
        m_vid = vid_req; m_vaddr = vid_addr;
        if (slot_old) begin
          if (!m_we) m_rd = {m_caddr[RW-1:0], ~m_caddr[RW-1:0]};
          m_slot = 0;
        end
      end
      if (!cpu_as) m_done = 0;
      else if (ph == 3 && slot_old) m_done = 1;
      else if (!cpu_dram && !done_old) m_done = 1;
      m_ph = (ph + 1) % 4;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) if (rst_ni) begin
    automatic bit e_ras = 0, e_cas = 0, e_we = 0, e_cs = 0;
    automatic logic [RW-1:0] e_ad = '0;
    automatic bit colp = m_ph[0];
    if (m_ph < 2) begin
      e_ras = 1;
      if (m_vid) begin
        e_cas = colp; e_cs = colp;
        e_ad = colp ? m_vaddr[RW-1:0] : m_vaddr[AW-1 -: RW];
      end else e_ad = m_ref;
    end else if (m_slot) begin
      e_ras = 1; e_cas = colp; e_cs = colp; e_we = m_we;
      e_ad = colp ? m_caddr[RW-1:0] : m_caddr[AW-1 -: RW];
    end
    chk(phase == m_ph[1:0], "R1 phase", phase, m_ph);
    chk(ras == e_ras && cas == e_cas && col_sel == e_cs, "R2/R3 strobes",
        {ras, cas, col_sel}, {e_ras, e_cas, e_cs});
    chk(daddr == e_ad, "R2/R3 address", daddr, e_ad);
    chk(we == e_we && dwdata == m_wd, "R8 write pins", {we, dwdata}, {e_we, m_wd});
    chk(cpu_ack == m_done, "R9 ack", cpu_ack, m_done);
    chk(cpu_rdata == m_rd, "R7 rdata", cpu_rdata, m_rd);
    chk(vid_ack == m_vack && vid_data == m_vd, "R11 video", {vid_ack, vid_data}, {m_vack, m_vd});
    chk(!(phase < 2 && we), "R4 we in display", we, 0);
  end

  task automatic wait_ph(input int p);
    while (phase != p[1:0]) @(negedge clk);
  endtask

  task automatic access(input bit d, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int start, input int exp_lat,
                        input string req);
    int lat = 0, nwe = 0;
    logic [DW-1:0] held;
    wait_ph(start);
    cpu_as = 1; cpu_dram = d; cpu_we = w; cpu_addr = a; cpu_wdata = wd;
    while (!cpu_ack && lat < 20) begin
      @(negedge clk); lat++;
      if (we) begin
        nwe++;
        chk(dwdata == wd, "R8 wdata", dwdata, wd);
      end
    end
    chk(lat == exp_lat, req, lat, exp_lat);
    if (d) chk(phase == 2'd0, "R6 ack phase", phase, 0);
    if (d && w) chk(nwe == 2, "R8 we count", nwe, 2);
    if (!d) chk(nwe == 0 && !ras || phase < 2, "R10 no dram", nwe, 0);
    if (d && !w) chk(cpu_rdata == {a[RW-1:0], ~a[RW-1:0]}, "R7 read value",
                     cpu_rdata, {a[RW-1:0], ~a[RW-1:0]});
    held = cpu_rdata;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(cpu_ack && cpu_rdata == held, "R7/R9 hold", {cpu_ack, cpu_rdata}, {1'b1, held});
      if (phase >= 2) chk(!cas && !we, "R9 no second slot", {cas, we}, 0);
    end
    cpu_as = 0;
    @(negedge clk);
    chk(!cpu_ack, "R9 release", cpu_ack, 0);
    @(negedge clk);
  endtask

  initial begin
    logic [RW-1:0] r0;
    repeat (3) @(negedge clk);
    chk(phase == 0 && !cpu_ack && !vid_ack && !cas, "R1 reset state",
        {phase, cpu_ack, vid_ack, cas}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(phase == 1, "R1 first step", phase, 1);

    // refresh sequence
    wait_ph(0);
    r0 = daddr;
    chk(ras && !cas, "R3 refresh strobes", {ras, cas}, 2'b10);
    @(negedge clk); @(negedge clk);
    wait_ph(0);
    chk(daddr == r0 + 1'b1, "R3 refresh step", daddr, r0 + 1'b1);

    // video over refresh
    vid_req = 1; vid_addr = 16'hA55A;
    wait_ph(3); @(negedge clk);
    chk(ras && !cas && daddr == 8'hA5, "R2 video row", {ras, cas, daddr}, {2'b10, 8'hA5});
    @(negedge clk);
    chk(cas && col_sel && daddr == 8'h5A, "R2 video col", {cas, col_sel, daddr}, {2'b11, 8'h5A});
    @(negedge clk);
    chk(vid_ack && vid_data == 16'h5AA5, "R11 video data", {vid_ack, vid_data}, {1'b1, 16'h5AA5});
    @(negedge clk);
    chk(!vid_ack, "R11 pulse width", vid_ack, 0);

    // processor accesses with video running
    access(1, 0, 16'h1234, '0, 1, 3, "R5 aligned latency");
    access(1, 0, 16'h4321, '0, 3, 5, "R6 misaligned latency");
    access(1, 1, 16'h0F0F, 16'hBEEF, 0, 4, "R6 phase0 latency");
    vid_req = 0;
    access(1, 1, 16'h7777, 16'hCAFE, 2, 6, "R6 phase2 latency");
    access(0, 0, 16'h0001, '0, 2, 1, "R10 bypass latency");
    access(0, 1, 16'h0002, 16'h1111, 0, 1, "R10 bypass phase0");
    access(1, 0, 16'h00FF, '0, 1, 3, "R5 refresh idle read");

    repeat (10) @(negedge clk);
    done_run = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done_run) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule